// File: doc/BRIEF.md
# Programmable Frame-Start Pulse Generator

This block drives the frame-start line of a panel gate-driver interface. The line goes high once per frame, on the first line of that frame. The edge that starts the pulse is measured from a per-line reference strobe, which marks where the shift clock would rise if its own offset were zero. Time is counted in line-clock ticks. A tick is a single-cycle enable that arrives once per divided dot-clock period.

A configuration word holds two fields: a delay from the reference strobe to the rising edge, and the number of ticks the pulse stays high. These fields apply only when two mode inputs are both set. One input selects the dot-clock interface and the other selects the programmable panel type. In every other mode combination the fields are ignored. The pulse then starts at the reference strobe and lasts exactly one line. Mode and configuration are captured when a frame's pulse starts, so later writes only affect the next frame.

Top module: `frame_pulse_gen`

## Requirements
- R1: A write stores bits 13:8 of the word as the width field and bits 2:0 as the delay field. From the cycle after the write, the read port returns these two fields in the same positions with every other bit 0, and it keeps that value until the next write.
- R2: While reset is high at a clock edge, both fields clear to 0 and the output goes low from the next cycle.
- R3: A line is the first line of a frame when a frame-start strobe is sampled in the same cycle as that line's reference strobe, or in an earlier cycle after the previous reference strobe. A pulse can begin only on such a line. Reference strobes without a preceding frame-start strobe produce no pulse.
- R4: In programmable mode (both mode inputs 1), a delay of 0 raises the output in the cycle after the reference strobe. A delay of D from 1 to 7 raises it in the cycle after the D-th tick that follows the reference strobe cycle.
- R5: In programmable mode the output falls in the cycle after the W-th tick that is sampled after the cycle in which the output rose, where W is the width field (1 to 63).
- R6: In programmable mode a width field of 0 produces no pulse for that frame.
- R7: When either mode input is 0, both fields and all ticks are ignored. The output is high from the cycle after the frame's first reference strobe until the cycle after the next reference strobe.
- R8: In programmable mode, reference strobes that arrive during the delay or the high time neither restart nor end the pulse, so the pulse may extend into following lines.
- R9: Fields and mode inputs are captured when a pulse starts. Changes made while a pulse is in progress do not alter it and take effect from the next frame start.
- R10: The output changes only in the cycle after a tick, a reference strobe or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write word |
| cfg_rdata | output | 16 | Configuration readback |
| line_tick | input | 1 | Divided dot-clock tick enable |
| line_ref | input | 1 | Per-line reference strobe |
| frame_start | input | 1 | Frame-start strobe |
| dot_mode | input | 1 | Dot-clock interface selected |
| prog_panel | input | 1 | Programmable panel type selected |
| flm | output | 1 | Frame-start pulse output |

## Verification
A wrong internal state appears at the output within the pulse it corrupts. A delay counter that is off by one moves the rising edge by one tick period. A width counter that is loaded or decremented incorrectly moves the falling edge. A lost pending-frame flag suppresses the entire pulse. Because the sweep compares the output in every cycle of every delay and width code against arithmetic edge positions, each such fault shows up in the first cycle where the edge is misplaced. A mode that is latched incorrectly shows as a pulse that ends on a reference strobe instead of on a tick, or the other way round.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  localparam int CFG_DW   = 16;
  localparam int POS_W    = 3;
  localparam int WID_W    = 6;
  localparam int POS_LSB  = 0;
  localparam int WID_LSB  = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_HIGH  = 2'd2,
    ST_LINE  = 2'd3
  } fpg_state_e;
endpackage

// File: rtl/fpg_cfg_regs.sv
module fpg_cfg_regs #(
  parameter int DATA_W  = 16,
  parameter int POS_W   = 3,
  parameter int WID_W   = 6,
  parameter int POS_LSB = 0,
  parameter int WID_LSB = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [POS_W-1:0]  pos,
  output logic [WID_W-1:0]  wid
);
  logic [POS_W-1:0] pos_q;
  logic [WID_W-1:0] wid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      wid_q <= '0;
    end else if (we) begin
      pos_q <= wdata[POS_LSB +: POS_W];
      wid_q <= wdata[WID_LSB +: WID_W];
    end
  end

  always_comb begin
    rdata = '0;
    rdata[POS_LSB +: POS_W] = pos_q;
    rdata[WID_LSB +: WID_W] = wid_q;
  end

  assign pos = pos_q;
  assign wid = wid_q;
endmodule

// File: rtl/fpg_frame_track.sv
module fpg_frame_track (
  input  logic clk,
  input  logic rst,
  input  logic line_ref,
  input  logic frame_start,
  output logic first_line
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst)           pend_q <= 1'b0;
    else if (line_ref) pend_q <= 1'b0;
    else if (frame_start) pend_q <= 1'b1;
  end

  assign first_line = line_ref & (pend_q | frame_start);
endmodule

// File: rtl/fpg_pulse_fsm.sv
module fpg_pulse_fsm
  import fpg_pkg::*;
#(
  parameter int POS_W = 3,
  parameter int WID_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             line_ref,
  input  logic             start,
  input  logic             prog_en,
  input  logic [POS_W-1:0] pos,
  input  logic [WID_W-1:0] wid,
  output logic             flm
);
  localparam logic [POS_W-1:0] POS_ONE = POS_W'(1);
  localparam logic [WID_W-1:0] WID_ONE = WID_W'(1);

  fpg_state_e       st_q;
  logic [POS_W-1:0] pcnt_q;
  logic [WID_W-1:0] wcnt_q;
  logic [WID_W-1:0] wid_lat_q;
  logic             flm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      pcnt_q    <= '0;
      wcnt_q    <= '0;
      wid_lat_q <= '0;
      flm_q     <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            if (prog_en) begin
              if (wid != '0) begin
                wid_lat_q <= wid;
                if (pos == '0) begin
                  st_q   <= ST_HIGH;
                  wcnt_q <= wid;
                  flm_q  <= 1'b1;
                end else begin
                  st_q   <= ST_DELAY;
                  pcnt_q <= pos;
                end
              end
            end else begin
              st_q  <= ST_LINE;
              flm_q <= 1'b1;
            end
          end
        end
        ST_DELAY: begin
          if (tick) begin
            if (pcnt_q == POS_ONE) begin
              st_q   <= ST_HIGH;
              wcnt_q <= wid_lat_q;
              flm_q  <= 1'b1;
            end else begin
              pcnt_q <= pcnt_q - POS_ONE;
            end
          end
        end
        ST_HIGH: begin
          if (tick) begin
            if (wcnt_q == WID_ONE) begin
              st_q  <= ST_IDLE;
              flm_q <= 1'b0;
            end else begin
              wcnt_q <= wcnt_q - WID_ONE;
            end
          end
        end
        ST_LINE: begin
          if (line_ref) begin
            st_q  <= ST_IDLE;
            flm_q <= 1'b0;
          end
        end
        default: begin
          st_q  <= ST_IDLE;
          flm_q <= 1'b0;
        end
      endcase
    end
  end

  assign flm = flm_q;
endmodule

// File: rtl/frame_pulse_gen.sv
module frame_pulse_gen
  import fpg_pkg::*;
#(
  parameter int DATA_W  = CFG_DW,
  parameter int POS_BITS = POS_W,
  parameter int WID_BITS = WID_W,
  parameter int POS_AT  = POS_LSB,
  parameter int WID_AT  = WID_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              line_tick,
  input  logic              line_ref,
  input  logic              frame_start,
  input  logic              dot_mode,
  input  logic              prog_panel,
  output logic              flm
);
  logic [POS_BITS-1:0] pos_f;
  logic [WID_BITS-1:0] wid_f;
  logic                first_line;
  logic                prog_en;

  assign prog_en = dot_mode & prog_panel;

  fpg_cfg_regs #(
    .DATA_W (DATA_W),
    .POS_W  (POS_BITS),
    .WID_W  (WID_BITS),
    .POS_LSB(POS_AT),
    .WID_LSB(WID_AT)
  ) u_regs (
    .clk  (clk),
    .rst  (rst),
    .we   (cfg_we),
    .wdata(cfg_wdata),
    .rdata(cfg_rdata),
    .pos  (pos_f),
    .wid  (wid_f)
  );

  fpg_frame_track u_track (
    .clk        (clk),
    .rst        (rst),
    .line_ref   (line_ref),
    .frame_start(frame_start),
    .first_line (first_line)
  );

  fpg_pulse_fsm #(
    .POS_W(POS_BITS),
    .WID_W(WID_BITS)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .tick    (line_tick),
    .line_ref(line_ref),
    .start   (first_line),
    .prog_en (prog_en),
    .pos     (pos_f),
    .wid     (wid_f),
    .flm     (flm)
  );
endmodule

// File: rtl/fpg_checker.sv
module fpg_checker #(
  parameter int DATA_W  = 16,
  parameter int POS_W   = 3,
  parameter int WID_W   = 6,
  parameter int POS_LSB = 0,
  parameter int WID_LSB = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              line_tick,
  input logic              line_ref,
  input logic              flm
);
  localparam logic [DATA_W-1:0] FIELD_MASK =
    (DATA_W'({WID_W{1'b1}}) << WID_LSB) | (DATA_W'({POS_W{1'b1}}) << POS_LSB);

  // R2
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!flm && cfg_rdata == '0));

  // R1
  write_readback_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> cfg_rdata == ($past(cfg_wdata) & FIELD_MASK));

  // R1
  readback_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(cfg_rdata));

  // R10
  rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flm) |-> ($past(line_tick) || $past(line_ref)));

  // R10
  fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flm) |-> ($past(line_tick) || $past(line_ref) || $past(rst)));
endmodule

bind frame_pulse_gen fpg_checker #(
  .DATA_W (DATA_W),
  .POS_W  (POS_BITS),
  .WID_W  (WID_BITS),
  .POS_LSB(POS_AT),
  .WID_LSB(WID_AT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_we   (cfg_we),
  .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata),
  .line_tick(line_tick),
  .line_ref (line_ref),
  .flm      (flm)
);

// File: tb/frame_pulse_gen_bench.sv
module frame_pulse_gen_bench;
  localparam int LINE_LEN = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        line_tick = 1'b0;
  logic        line_ref = 1'b0;
  logic        frame_start = 1'b0;
  logic        dot_mode = 1'b0;
  logic        prog_panel = 1'b0;
  logic        flm;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  frame_pulse_gen u_frame_pulse_gen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .line_tick(line_tick), .line_ref(line_ref),
    .frame_start(frame_start), .dot_mode(dot_mode), .prog_panel(prog_panel),
    .flm(flm)
  );

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic bit exp_flm(input int k, input int p, input int w,
                                 input bit prog, input bit nofs);
    int rise_c, fall_c;
    if (nofs) return 1'b0;
    if (!prog) return (k >= 0 && k < LINE_LEN);
    if (w == 0) return 1'b0;
    rise_c = (p == 0) ? 0 : 2 * p - 1;
    fall_c = 2 * (p + w) - 1;
    return (k >= rise_c && k < fall_c);
  endfunction

  // One frame: ticks on odd cycles, reference strobes every LINE_LEN cycles.
  task automatic run(input string req, input int p, input int w, input bit dm,
                     input bit lt, input bit early, input bit nofs, input bit midw);
    int n, bad_k, bad_act, bad_exp, nbad;
    bit prog;
    prog = dm & lt;
    n = ((2 * (p + w) > LINE_LEN) ? 2 * (p + w) : LINE_LEN) + 8;
    nbad = 0; bad_k = 0; bad_act = 0; bad_exp = 0;
    dot_mode = dm;
    prog_panel = lt;
    for (int k = -3; k <= n; k++) begin
      @(negedge clk);
      if (k - 1 >= 0 && flm !== exp_flm(k - 1, p, w, prog, nofs)) begin
        if (nbad == 0) begin
          bad_k = k - 1; bad_act = int'(flm); bad_exp = int'(exp_flm(k - 1, p, w, prog, nofs));
        end
        nbad++;
      end
      line_tick   = (k > 0 && (k % 2) == 1);
      line_ref    = (k >= 0 && (k % LINE_LEN) == 0);
      frame_start = !nofs && (k == (early ? -3 : 0));
      cfg_we      = midw && (k == 5);
      cfg_wdata   = 16'h0100;
      if (midw && k == 5) begin
        dot_mode = 1'b0;
        prog_panel = 1'b0;
      end
    end
    @(negedge clk);
    if (flm !== exp_flm(n, p, w, prog, nofs) && nbad == 0) begin
      bad_k = n; bad_act = int'(flm); bad_exp = int'(exp_flm(n, p, w, prog, nofs)); nbad++;
    end
    line_tick = 1'b0; line_ref = 1'b0; frame_start = 1'b0; cfg_we = 1'b0;
    checks++;
    if (nbad != 0) begin
      errors++;
      $display("FAIL %s: pos=%0d wid=%0d cycle %0d flm=%0d expected %0d",
               req, p, w, bad_k, bad_act, bad_exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2: reset state
    check16("R2 readback after reset", cfg_rdata, 16'h0000);
    check16("R2 output after reset", {15'b0, flm}, 16'h0000);

    // R1: field placement and masking
    wr_cfg(16'hFFFF);
    check16("R1 all ones", cfg_rdata, 16'h3F07);
    wr_cfg(16'hA5C3);
    check16("R1 mixed word", cfg_rdata, 16'h2503);
    repeat (3) @(negedge clk);
    check16("R1 hold without write", cfg_rdata, 16'h2503);

    // R2: reset clears written fields
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check16("R2 fields cleared", cfg_rdata, 16'h0000);

    // R4 R5 R6 R8: sweep every delay and width code in programmable mode
    for (int p = 0; p < 8; p++) begin
      for (int w = 0; w < 64; w++) begin
        wr_cfg(16'((w << 8) | p));
        run((w == 0) ? "R6 zero width" : "R4 R5 R8 prog sweep", p, w, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      end
    end

    // R7: fallback in each non-programmable mode, fields ignored
    wr_cfg(16'h0503);
    run("R7 fallback dm0 lt0", 3, 5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R7 fallback dm1 lt0", 3, 5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R7 fallback dm0 lt1", 3, 5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    wr_cfg(16'h0000);
    run("R7 fallback zero fields", 0, 0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

    // R3: frame strobe ahead of reference, and no frame strobe at all
    wr_cfg(16'h0402);
    run("R3 early frame strobe", 2, 4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    run("R3 early frame strobe fallback", 2, 4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    run("R3 no frame strobe", 2, 4, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);

    // R9: mid-pulse write and mode change do not alter the pulse
    wr_cfg(16'h0A01);
    run("R9 mid-pulse change", 1, 10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    check16("R9 new value stored", cfg_rdata, 16'h0100);
    run("R9 next frame uses new value", 0, 1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule